// File: doc/BRIEF.md
# Debug Command Frame Decoder

This block sits behind the debug data register of a JTAG test access port. While the debug instruction is loaded, the TAP controller gives it a one-cycle capture strobe, a shift enable for each Shift-DR clock and a one-cycle update strobe. Serial data arrives on `tdi` LSB first and enters a shift register from its MSB side, so the last bit of any frame always ends up in the top position. On the update strobe the block looks at that top bit. When it is 1, the frame selects a debug unit and a 2-bit unit identifier is latched. When it is 0, the next four bits are a command opcode and the bits below them are its fields.

A burst command latches its opcode, a 32-bit start address and a 16-bit word count, pulses a start strobe to the burst engines, and marks a burst as pending until the engine reports completion. While a burst is pending, no new command is accepted. Register-select and register-write commands pulse their own strobes with an index and, for writes, a data word. A frame of zeros is a no-operation. During any shift, the value presented on `reg_rd_data` at capture time comes out on `tdo`, LSB first. The TAP's Test-Logic-Reset state clears the unit selection and any pending burst.

Top module: `dbg_cmd_decoder`

## Requirements
- R1: After `rst_n` is asserted, `sel_module` is 0, `burst_pending` is 0, and `burst_start`, `reg_wr_strobe` and `reg_sel_strobe` are 0.
- R2: On update, if the top bit is 1, `sel_module` takes the two bits shifted just before it. A 3-bit frame holds the identifier LSB first and then a 1. The selection is accepted even while a burst is pending.
- R3: A 53-bit command frame holds, in shift order, a 16-bit count, a 32-bit address, a 4-bit opcode and a 0. If the opcode is one of the burst codes (0x1, 0x2 or 0x3 for writes of 8, 16 or 32-bit words; 0x5, 0x6 or 0x7 for reads of 8, 16 or 32-bit words), then in the cycle after update `burst_start` is high for one cycle, `burst_pending` is 1, and `burst_opcode`, `burst_addr` and `burst_count` hold the frame's fields.
- R4: While `burst_pending` is 1, command frames are ignored. No strobe pulses, and the latched opcode, address, count, index and write data stay unchanged.
- R5: A one-cycle `burst_done` clears `burst_pending` on the next clock.
- R6: A command frame with opcode 0x9 holds, in shift order, DATA_W data bits, IDX_W index bits, the opcode and a 0. It pulses `reg_wr_strobe` for one cycle and sets `reg_index` and `reg_wr_data` to its fields.
- R7: A command frame with opcode 0xD holds, in shift order, IDX_W index bits, the opcode and a 0. It pulses `reg_sel_strobe` for one cycle and sets `reg_index`.
- R8: A frame of all zeros, or a command frame with any other opcode (for example 0x4), pulses no strobe and changes no latched output.
- R9: During the shift cycles that follow a capture, `tdo` presents the value of `reg_rd_data` sampled at capture, LSB first, one bit per shift.
- R10: `tap_reset` clears `sel_module` to 0 and `burst_pending` to 0 on the next clock, and it takes priority over a simultaneous update.
- R11: Shifting without an update strobe starts no command and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tap_reset | input | 1 | TAP is in Test-Logic-Reset |
| capture_en | input | 1 | Capture-DR strobe for the debug register |
| shift_en | input | 1 | Shift-DR enable for the debug register |
| update_en | input | 1 | Update-DR strobe for the debug register |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| reg_rd_data | input | DATA_W | Contents of the selected internal register |
| burst_done | input | 1 | Burst engine finished the pending burst |
| sel_module | output | 2 | Selected debug unit identifier |
| burst_start | output | 1 | One-cycle start strobe for a burst |
| burst_pending | output | 1 | A burst has started and has not yet finished |
| burst_opcode | output | 4 | Opcode of the latched burst |
| burst_addr | output | 32 | Start address of the latched burst |
| burst_count | output | 16 | Word count of the latched burst |
| reg_sel_strobe | output | 1 | One-cycle internal-register select strobe |
| reg_wr_strobe | output | 1 | One-cycle internal-register write strobe |
| reg_index | output | IDX_W | Internal-register index |
| reg_wr_data | output | DATA_W | Internal-register write data |

## Verification
Field extraction depends on the frame's final bits always landing at the top of the register. An off-by-one shift or a wrong field slice therefore shows up as a corrupted address, count, index or data word in the cycle right after the update strobe. A pending flag that is set wrongly or never cleared appears as a missing start strobe on the next burst frame. A flag that fails to block appears as a second start strobe while the first burst is still open. A readout path that is misaligned shows up on `tdo` during the very first shift cycle after capture.

// File: rtl/dbg_cmd_decoder.sv
module dbg_cmd_decoder #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32,
  parameter int SR_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tap_reset,
  input  logic              capture_en,
  input  logic              shift_en,
  input  logic              update_en,
  input  logic              tdi,
  output logic              tdo,
  input  logic [DATA_W-1:0] reg_rd_data,
  input  logic              burst_done,
  output logic [1:0]        sel_module,
  output logic              burst_start,
  output logic              burst_pending,
  output logic [3:0]        burst_opcode,
  output logic [31:0]       burst_addr,
  output logic [15:0]       burst_count,
  output logic              reg_sel_strobe,
  output logic              reg_wr_strobe,
  output logic [IDX_W-1:0]  reg_index,
  output logic [DATA_W-1:0] reg_wr_data
);

  localparam int TOP     = SR_W - 1;
  localparam int OP_HI   = SR_W - 2;
  localparam int OP_LO   = SR_W - 5;
  localparam int FLD_HI  = OP_LO - 1;
  localparam int ADDR_LO = FLD_HI - 31;
  localparam int CNT_LO  = ADDR_LO - 16;
  localparam int IDX_LO  = FLD_HI - IDX_W + 1;
  localparam int DAT_LO  = IDX_LO - DATA_W;
  localparam int LOW     = (DAT_LO < CNT_LO) ? DAT_LO : CNT_LO;

  localparam logic [3:0] OP_WR8  = 4'h1;
  localparam logic [3:0] OP_WR16 = 4'h2;
  localparam logic [3:0] OP_WR32 = 4'h3;
  localparam logic [3:0] OP_RD8  = 4'h5;
  localparam logic [3:0] OP_RD16 = 4'h6;
  localparam logic [3:0] OP_RD32 = 4'h7;
  localparam logic [3:0] OP_REGW = 4'h9;
  localparam logic [3:0] OP_REGS = 4'hD;

  logic [TOP:LOW]    sr;
  logic [DATA_W-1:0] out_sr;
  logic [3:0]        op;
  logic              is_burst;

  assign op  = sr[OP_HI:OP_LO];
  assign tdo = out_sr[0];

  always_comb begin
    case (op)
      OP_WR8, OP_WR16, OP_WR32, OP_RD8, OP_RD16, OP_RD32: is_burst = 1'b1;
      default: is_burst = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      out_sr <= '0;
    end else if (capture_en) begin
      sr     <= '0;
      out_sr <= reg_rd_data;
    end else if (shift_en) begin
      sr     <= {tdi, sr[TOP:LOW+1]};
      out_sr <= {1'b0, out_sr[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_module     <= '0;
      burst_start    <= 1'b0;
      burst_pending  <= 1'b0;
      burst_opcode   <= '0;
      burst_addr     <= '0;
      burst_count    <= '0;
      reg_sel_strobe <= 1'b0;
      reg_wr_strobe  <= 1'b0;
      reg_index      <= '0;
      reg_wr_data    <= '0;
    end else begin
      burst_start    <= 1'b0;
      reg_sel_strobe <= 1'b0;
      reg_wr_strobe  <= 1'b0;
      if (tap_reset) begin
        sel_module    <= '0;
        burst_pending <= 1'b0;
      end else begin
        if (burst_done) burst_pending <= 1'b0;
        if (update_en) begin
          if (sr[TOP]) begin
            sel_module <= sr[OP_HI:OP_HI-1];
          end else if (!burst_pending) begin
            if (is_burst) begin
              burst_start   <= 1'b1;
              burst_pending <= 1'b1;
              burst_opcode  <= op;
              burst_addr    <= sr[FLD_HI:ADDR_LO];
              burst_count   <= sr[ADDR_LO-1:CNT_LO];
            end else if (op == OP_REGW) begin
              reg_wr_strobe <= 1'b1;
              reg_index     <= sr[FLD_HI:IDX_LO];
              reg_wr_data   <= sr[IDX_LO-1:DAT_LO];
            end else if (op == OP_REGS) begin
              reg_sel_strobe <= 1'b1;
              reg_index      <= sr[FLD_HI:IDX_LO];
            end
          end
        end
      end
    end
  end

  a_r4_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    burst_pending |=> !burst_start);

  a_r4_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    burst_pending |=> ($stable(burst_addr) && $stable(burst_opcode) && $stable(burst_count)));

  a_r3_start_marks_pending: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |-> burst_pending);

  a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_pending && burst_done) |=> !burst_pending);

  a_r10_tap_reset: assert property (@(posedge clk) disable iff (!rst_n)
    tap_reset |=> (sel_module == 2'd0 && !burst_pending));

  a_r11_update_only: assert property (@(posedge clk) disable iff (!rst_n)
    !update_en |=> (!burst_start && !reg_wr_strobe && !reg_sel_strobe));

  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({burst_start, reg_wr_strobe, reg_sel_strobe}));

endmodule

// File: tb/dbg_cmd_decoder_tb.sv
module dbg_cmd_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W  = 4;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tap_reset = 1'b0, capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0, tdi = 1'b0;
  logic tdo;
  logic [DATA_W-1:0] reg_rd_data = '0;
  logic burst_done = 1'b0;
  logic [1:0] sel_module;
  logic burst_start, burst_pending, reg_sel_strobe, reg_wr_strobe;
  logic [3:0] burst_opcode;
  logic [31:0] burst_addr;
  logic [15:0] burst_count;
  logic [IDX_W-1:0] reg_index;
  logic [DATA_W-1:0] reg_wr_data;

  int checks = 0, failures = 0;
  logic [63:0] tdo_bits;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_cmd_decoder #(.IDX_W(IDX_W), .DATA_W(DATA_W), .SR_W(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .tap_reset(tap_reset), .capture_en(capture_en),
    .shift_en(shift_en), .update_en(update_en), .tdi(tdi), .tdo(tdo),
    .reg_rd_data(reg_rd_data), .burst_done(burst_done), .sel_module(sel_module),
    .burst_start(burst_start), .burst_pending(burst_pending),
    .burst_opcode(burst_opcode), .burst_addr(burst_addr), .burst_count(burst_count),
    .reg_sel_strobe(reg_sel_strobe), .reg_wr_strobe(reg_wr_strobe),
    .reg_index(reg_index), .reg_wr_data(reg_wr_data));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [63:0] v, input int len, input bit do_update);
    @(negedge clk); capture_en = 1'b1;
    @(negedge clk); capture_en = 1'b0; shift_en = 1'b1;
    tdo_bits = '0;
    for (int i = 0; i < len; i++) begin
      tdi = v[i];
      tdo_bits[i] = tdo;
      @(negedge clk);
    end
    shift_en = 1'b0; tdi = 1'b0;
    if (do_update) begin
      update_en = 1'b1;
      @(negedge clk);
      update_en = 1'b0;
    end
  endtask

  function automatic logic [63:0] burst_frame(input logic [3:0] op, input logic [31:0] a, input logic [15:0] c);
    return {11'h0, 1'b0, op, a, c};
  endfunction

  function automatic logic [63:0] strobes();
    return {61'h0, burst_start, reg_wr_strobe, reg_sel_strobe};
  endfunction

  task automatic t_reset;
    check("R1 sel_module", sel_module, 0);
    check("R1 pending", burst_pending, 0);
    check("R1 strobes", strobes(), 0);
  endtask

  task automatic t_select;
    run_frame({61'h0, 1'b1, 2'd2}, 3, 1);
    check("R2 select 2", sel_module, 2);
    run_frame({61'h0, 1'b1, 2'd1}, 3, 1);
    check("R2 select 1", sel_module, 1);
  endtask

  task automatic t_burst;
    run_frame(burst_frame(4'h3, 32'hDEADBEEC, 16'h0010), 53, 1);
    check("R3 start pulse", burst_start, 1);
    check("R3 pending", burst_pending, 1);
    check("R3 opcode", burst_opcode, 4'h3);
    check("R3 addr", burst_addr, 32'hDEADBEEC);
    check("R3 count", burst_count, 16'h0010);
    @(negedge clk);
    check("R3 single pulse", burst_start, 0);
  endtask

  task automatic t_blocked;
    run_frame(burst_frame(4'h5, 32'h12345678, 16'h0003), 53, 1);
    check("R4 no start", strobes(), 0);
    check("R4 addr held", burst_addr, 32'hDEADBEEC);
    check("R4 opcode held", burst_opcode, 4'h3);
    run_frame({23'h0, 1'b0, 4'h9, 4'h7, 32'h55AA55AA}, 41, 1);
    check("R4 no reg write", strobes(), 0);
    check("R4 wdata held", reg_wr_data, 0);
    run_frame({61'h0, 1'b1, 2'd3}, 3, 1);
    check("R2 select while busy", sel_module, 3);
  endtask

  task automatic t_done;
    @(negedge clk); burst_done = 1'b1;
    @(negedge clk); burst_done = 1'b0;
    check("R5 pending cleared", burst_pending, 0);
    run_frame(burst_frame(4'h5, 32'h00000000, 16'hFFFF), 53, 1);
    check("R3 read8 start", burst_start, 1);
    check("R3 read8 count", burst_count, 16'hFFFF);
    check("R3 read8 addr", burst_addr, 0);
    @(negedge clk); burst_done = 1'b1;
    @(negedge clk); burst_done = 1'b0;
    check("R5 pending cleared again", burst_pending, 0);
  endtask

  task automatic t_regs;
    run_frame({23'h0, 1'b0, 4'h9, 4'h5, 32'hCAFEF00D}, 41, 1);
    check("R6 write strobe", strobes(), 3'b010);
    check("R6 index", reg_index, 4'h5);
    check("R6 data", reg_wr_data, 32'hCAFEF00D);
    run_frame({55'h0, 1'b0, 4'hD, 4'hA}, 9, 1);
    check("R7 select strobe", strobes(), 3'b001);
    check("R7 index", reg_index, 4'hA);
    check("R7 data kept", reg_wr_data, 32'hCAFEF00D);
  endtask

  task automatic t_nop_readout;
    reg_rd_data = 32'h9234_5671;
    run_frame(64'h0, 36, 1);
    check("R9 tdo stream", tdo_bits[35:0], {4'h0, 32'h9234_5671});
    check("R8 nop strobes", strobes(), 0);
    check("R8 nop index", reg_index, 4'hA);
    run_frame(burst_frame(4'h4, 32'h11112222, 16'h0004), 53, 1);
    check("R8 bad opcode strobes", strobes(), 0);
    check("R8 bad opcode pending", burst_pending, 0);
    check("R8 bad opcode addr", burst_addr, 0);
  endtask

  task automatic t_no_update;
    run_frame(burst_frame(4'h2, 32'hABCD0000, 16'h0008), 53, 0);
    @(negedge clk);
    check("R11 no start", strobes(), 0);
    check("R11 no pending", burst_pending, 0);
    check("R11 addr unchanged", burst_addr, 0);
  endtask

  task automatic t_tap_reset;
    run_frame(burst_frame(4'h1, 32'h00000040, 16'h0002), 53, 1);
    check("R3 write8 start", burst_start, 1);
    @(negedge clk); tap_reset = 1'b1;
    @(negedge clk); tap_reset = 1'b0;
    check("R10 sel cleared", sel_module, 0);
    check("R10 pending cleared", burst_pending, 0);
    run_frame({61'h0, 1'b1, 2'd2}, 3, 0);
    update_en = 1'b1; tap_reset = 1'b1;
    @(negedge clk); update_en = 1'b0; tap_reset = 1'b0;
    check("R10 priority over update", sel_module, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_select;
    t_burst;
    t_blocked;
    t_done;
    t_regs;
    t_nop_readout;
    t_no_update;
    t_tap_reset;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule